// File: doc/BRIEF.md
# Delay Line Select Load Controller

This block decides when and how new delay-select codes reach five delay lines in one data lane of a memory PHY. When the active rank changes and the lane needs a different delay, a new code appears on the select inputs while the bus may still be busy. The block watches the gate (bus-activity) input. It waits for an idle cycle and raises a single load strobe. Each line's holding register then takes the new code from the strobe, or reloads on every cycle.

A 32-bit control register sets the behaviour:
- the strobe timing;
- whether the two pipelined lines, line 0 and line 1, take their code directly;
- change-only or continuous reloading, chosen per line;
- the bypass mode;
- a 16-bit per-line bypass field.

A bypassed line drives code zero to its delay line. The bypass resolution also drives a 16-bit flag vector with one flag per delay line in the lane.

The strobe comes from a three-state machine:
- SPENT: the strobe has been used up, or reset has just ended.
- ARMED: bus activity has been seen since the last strobe.
- DELAY: an idle cycle was seen with late timing selected.

The transitions are:
- arm: SPENT to ARMED when the gate is high.
- fire_early: ARMED to SPENT on an idle cycle with early timing. The strobe fires in that same cycle.
- defer: ARMED to DELAY on an idle cycle with late timing.
- fire_late: DELAY always fires. It goes to ARMED if the gate is high in that cycle, and to SPENT if it is not.
- hold: a state stays where it is otherwise.

Top module: `dly_sel_load_ctrl`

## Requirements
- R1: While reset is applied and right after it, the control register reads 0x00000002, the strobe is low, and every applied code and bypass flag is 0.
- R2: A register write stores only bits 26, 25 and 22:0. Bits 31:27 and 24:23 always read 0.
- R3: With the timing bit (26) at 0, the strobe is high in the first cycle where the gate is low after a cycle where it was high. It stays high for that one cycle only.
- R4: With the timing bit at 1, the strobe is high exactly one cycle after that first idle cycle, whatever the gate does in that later cycle.
- R5: Only one strobe is produced per idle period. No further strobe appears until the gate has been high again, and none appears after reset until the gate has first been high.
- R6: With a line's dynamic-load bit (bit 18+line) at 0, its holding register takes the select code only at a clock edge where the strobe is high. Otherwise it keeps its value.
- R7: With a line's dynamic-load bit at 1, its holding register takes the select code at every clock edge, so the applied code follows the select input one cycle later.
- R8: With the load-type bit (25) at 1, lines 0 and 1 apply the select input in the same cycle and ignore the strobe. Lines 2 to 4 keep applying their holding register.
- R9: The bypass mode is bits 1:0. In mode 00 each flag follows its bit in the per-line field (bits 17:2). Mode 01 sets every flag. Modes 10 and 11 clear every flag.
- R10: Flags 4 and 5 are always 0. Lines 0 to 4 use flags 13, 14, 9, 10 and 11. A line whose flag is set applies code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write enable for the control register |
| cfg_wdata_i | input | 32 | Control word to store |
| cfg_rdata_o | output | 32 | Control register contents, reserved bits zero |
| gate_i | input | 1 | High while the bus is active in this cycle |
| sel_i | input | 5*SEL_W | New select code per line, line 0 in the low bits |
| ld_o | output | 1 | Load strobe |
| code_o | output | 5*SEL_W | Select code applied to each delay line |
| byp_o | output | 16 | Bypass flag per delay line of the lane |

## Verification
On every cycle the assertions check the following:
- a strobe only appears in an idle cycle or right after one;
- a strobe in an idle cycle is never followed by another;
- the late state always follows an idle cycle;
- holding registers stay still without a strobe, or copy the select input under continuous load;
- bypassed lines drive zero and the unused flags stay low;
- reserved register bits read zero.

Only the bench's scenarios can show the following:
- the strobe lands in the exact cycle the timing bit asks for, across idle runs of one to four cycles;
- codes captured under change-only load survive later configuration changes;
- the direct path and the bypass masks give the right code for every mix of load type, dynamic-load pattern and bypass mode.

// File: rtl/dls_pkg.sv
package dls_pkg;

    // Number of delay lines whose select codes are managed (one dynamic-load bit each)
    localparam int unsigned DYN_W  = 5;
    // Number of bypass flags in the lane
    localparam int unsigned BYP_W  = 16;
    localparam int unsigned WORD_W = 32;

    // Control word field positions, decoded by the register block
    localparam int unsigned F_MODE   = 0;
    localparam int unsigned F_BYP    = 2;
    localparam int unsigned F_DYN    = 18;
    localparam int unsigned F_DIRECT = 25;
    localparam int unsigned F_LATE   = 26;

    localparam logic [WORD_W-1:0] CTRL_RESET = 32'h0000_0002;
    localparam logic [WORD_W-1:0] CTRL_WMASK = 32'h067F_FFFF;
    // Flags with no delay line behind them
    localparam logic [BYP_W-1:0]  BYP_UNUSED = 16'h0030;

    typedef enum logic [1:0] {
        ST_SPENT = 2'd0,
        ST_ARMED = 2'd1,
        ST_DELAY = 2'd2
    } strobe_st_e;

    typedef enum logic [1:0] {
        BM_PERLINE = 2'b00,
        BM_ALL     = 2'b01,
        BM_NONE    = 2'b10,
        BM_RSVD    = 2'b11
    } byp_mode_e;

    typedef struct packed {
        logic             late;
        logic             direct;
        logic [DYN_W-1:0] dyn;
        logic [BYP_W-1:0] byp;
        logic [1:0]       mode;
    } dls_cfg_t;

    // Which bypass flag governs each managed line
    function automatic int unsigned line_byp_bit(input int unsigned ln);
        int unsigned b;
        case (ln)
            0:       b = 13;
            1:       b = 14;
            2:       b = 9;
            3:       b = 10;
            4:       b = 11;
            default: b = 0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/dls_ctrl_reg.sv
module dls_ctrl_reg
    import dls_pkg::*;
#(
    parameter logic [WORD_W-1:0] RST_WORD = CTRL_RESET,
    parameter logic [WORD_W-1:0] WR_MASK  = CTRL_WMASK
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    output dls_cfg_t          cfg_o
);

    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            word_q <= RST_WORD & WR_MASK;
        end else if (we_i) begin
            word_q <= wdata_i & WR_MASK;
        end
    end

    assign rdata_o = word_q;

    always_comb begin
        cfg_o.late   = word_q[F_LATE];
        cfg_o.direct = word_q[F_DIRECT];
        cfg_o.dyn    = word_q[F_DYN +: DYN_W];
        cfg_o.byp    = word_q[F_BYP +: BYP_W];
        cfg_o.mode   = word_q[F_MODE +: 2];
    end

    // R2: reserved bits never become visible
    p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rdata_o & ~WR_MASK) == '0);

    // R2: a write lands masked in the following cycle
    p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |=> rdata_o == ($past(wdata_i) & WR_MASK));

endmodule

// File: rtl/dls_strobe_fsm.sv
module dls_strobe_fsm
    import dls_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic gate_i,
    input  logic late_i,
    output logic ld_o
);

    strobe_st_e st_q, st_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= ST_SPENT;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_SPENT: begin
                if (gate_i) st_d = ST_ARMED;                 // arm
            end
            ST_ARMED: begin
                if (!gate_i) begin
                    st_d = late_i ? ST_DELAY : ST_SPENT;      // defer / fire_early
                end
            end
            ST_DELAY: begin
                st_d = gate_i ? ST_ARMED : ST_SPENT;          // fire_late
            end
            default: st_d = ST_SPENT;
        endcase
    end

    always_comb begin
        ld_o = 1'b0;
        unique case (st_q)
            ST_SPENT: ld_o = 1'b0;
            ST_ARMED: ld_o = !gate_i && !late_i;
            ST_DELAY: ld_o = 1'b1;
            default:  ld_o = 1'b0;
        endcase
    end

    // R3: a strobe only appears in an idle cycle or just after one
    p_idle_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_o |-> (!gate_i || $past(!gate_i)));

    // R4: the late state is reached only from an idle cycle with late timing
    p_late_follows_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_DELAY) |-> ($past(!gate_i) && $past(late_i) && ld_o));

    // R5: a strobe in an idle cycle is not repeated
    p_single_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ld_o && !gate_i) |=> !ld_o);

endmodule

// File: rtl/dls_line.sv
module dls_line #(
    parameter int unsigned SEL_W     = 9,
    parameter bit          PIPELINED = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             ld_i,
    input  logic             dyn_i,
    input  logic             direct_i,
    input  logic             byp_i,
    output logic [SEL_W-1:0] code_o
);

    logic [SEL_W-1:0] hold_q;
    logic             take;
    logic             use_direct;

    // change-only load: capture on strobe when the code differs
    assign take = dyn_i || (ld_i && (sel_i != hold_q));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hold_q <= '0;
        end else if (take) begin
            hold_q <= sel_i;
        end
    end

    generate
        if (PIPELINED) begin : g_pipe
            assign use_direct = direct_i;
        end else begin : g_plain
            assign use_direct = direct_i & 1'b0;
        end
    endgenerate

    always_comb begin
        if (byp_i) begin
            code_o = '0;
        end else if (use_direct) begin
            code_o = sel_i;
        end else begin
            code_o = hold_q;
        end
    end

    // R6: without strobe or continuous load the holding register is frozen
    p_hold_still_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dyn_i && !ld_i) |=> $stable(hold_q));

    // R7: continuous load copies the select input every edge
    p_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dyn_i |=> hold_q == $past(sel_i));

    // R10: a bypassed line drives zero
    p_byp_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        byp_i |-> code_o == '0);

endmodule

// File: rtl/dls_bypass.sv
module dls_bypass
    import dls_pkg::*;
#(
    parameter logic [BYP_W-1:0] UNUSED = BYP_UNUSED
) (
    input  logic [1:0]       mode_i,
    input  logic [BYP_W-1:0] perline_i,
    output logic [BYP_W-1:0] byp_o
);

    byp_mode_e mode;
    assign mode = byp_mode_e'(mode_i);

    always_comb begin
        byp_o = '0;
        unique case (mode)
            BM_PERLINE: byp_o = perline_i & ~UNUSED;
            BM_ALL:     byp_o = ~UNUSED;
            BM_NONE:    byp_o = '0;
            BM_RSVD:    byp_o = '0;
            default:    byp_o = '0;
        endcase
    end

endmodule

// File: rtl/dly_sel_load_ctrl.sv
module dly_sel_load_ctrl
    import dls_pkg::*;
#(
    parameter int unsigned      SEL_W     = 9,
    parameter logic [DYN_W-1:0] PIPE_MASK = 5'b00011
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   cfg_we_i,
    input  logic [WORD_W-1:0]      cfg_wdata_i,
    output logic [WORD_W-1:0]      cfg_rdata_o,
    input  logic                   gate_i,
    input  logic [DYN_W*SEL_W-1:0] sel_i,
    output logic                   ld_o,
    output logic [DYN_W*SEL_W-1:0] code_o,
    output logic [BYP_W-1:0]       byp_o
);

    localparam int unsigned NUM_LINES = DYN_W;

    dls_cfg_t cfg;
    logic     ld;

    dls_ctrl_reg u_reg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .rdata_o (cfg_rdata_o),
        .cfg_o   (cfg)
    );

    dls_strobe_fsm u_fsm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .gate_i (gate_i),
        .late_i (cfg.late),
        .ld_o   (ld)
    );

    assign ld_o = ld;

    dls_bypass u_byp (
        .mode_i    (cfg.mode),
        .perline_i (cfg.byp),
        .byp_o     (byp_o)
    );

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            localparam int unsigned BB = line_byp_bit(i);
            dls_line #(
                .SEL_W     (SEL_W),
                .PIPELINED (PIPE_MASK[i])
            ) u_line (
                .clk_i    (clk_i),
                .rst_ni   (rst_ni),
                .sel_i    (sel_i[i*SEL_W +: SEL_W]),
                .ld_i     (ld),
                .dyn_i    (cfg.dyn[i]),
                .direct_i (cfg.direct),
                .byp_i    (byp_o[BB]),
                .code_o   (code_o[i*SEL_W +: SEL_W])
            );
        end
    endgenerate

    // R10: flags without a delay line stay low
    p_unused_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (byp_o & BYP_UNUSED) == '0);

    // R9: mode 01 sets every real flag
    p_mode_all_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_rdata_o[1:0] == 2'b01) |-> (byp_o == ~BYP_UNUSED));

    // R9: modes 10 and 11 clear every flag
    p_mode_none_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_rdata_o[1] |-> (byp_o == '0));

endmodule

// File: tb/dly_sel_load_ctrl_tb.sv
module dly_sel_load_ctrl_tb;

    localparam int SEL_W = 9;
    localparam int NL    = 5;
    localparam logic [31:0] MASK = 32'h067F_FFFF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              we = 1'b0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              gate = 1'b0;
    logic [NL*SEL_W-1:0] sel = '0;
    logic              ld;
    logic [NL*SEL_W-1:0] code;
    logic [15:0]       byp;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    // model state
    logic [31:0]      m_cfg;
    logic [SEL_W-1:0] m_hold [NL];
    bit               m_armed;
    bit               m_pend;
    int               lb [NL] = '{13, 14, 9, 10, 11};

    always #10 clk = ~clk;   // 50 MHz

    dly_sel_load_ctrl #(.SEL_W(SEL_W)) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cfg_we_i    (we),
        .cfg_wdata_i (wdata),
        .cfg_rdata_o (rdata),
        .gate_i      (gate),
        .sel_i       (sel),
        .ld_o        (ld),
        .code_o      (code),
        .byp_o       (byp)
    );

    function automatic logic [15:0] exp_byp(input logic [31:0] c);
        case (c[1:0])
            2'b00:   return c[17:2] & 16'hFFCF;
            2'b01:   return 16'hFFCF;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [SEL_W-1:0] gen_sel(input int c, input int i);
        return SEL_W'((c * 37 + i * 101 + 7) % 512);
    endfunction

    // one clock cycle: drive, compare, advance the model
    task automatic cycle(input logic g, input logic w, input logic [31:0] wd);
        logic        e_ld;
        logic [15:0] e_byp;
        logic [SEL_W-1:0] e_code, a_code, s;
        gate  = g;
        we    = w;
        wdata = wd;
        for (int i = 0; i < NL; i++) sel[i*SEL_W +: SEL_W] = gen_sel(cyc, i);
        #1;
        n_vec++;
        e_ld  = (m_armed && !g && !m_cfg[26]) || m_pend;
        e_byp = exp_byp(m_cfg);
        if (ld !== e_ld) begin
            n_bad++;
            if (!m_armed && !m_pend)
                $display("FAIL R5 cyc %0d strobe act=%0b exp=%0b", cyc, ld, e_ld);
            else if (m_cfg[26])
                $display("FAIL R4 cyc %0d strobe act=%0b exp=%0b", cyc, ld, e_ld);
            else
                $display("FAIL R3 cyc %0d strobe act=%0b exp=%0b", cyc, ld, e_ld);
        end
        if (rdata !== m_cfg) begin
            n_bad++;
            $display("FAIL R2 cyc %0d rdata act=%h exp=%h", cyc, rdata, m_cfg);
        end
        if (byp !== e_byp) begin
            n_bad++;
            $display("FAIL R9 cyc %0d bypass act=%h exp=%h", cyc, byp, e_byp);
        end
        for (int i = 0; i < NL; i++) begin
            s      = sel[i*SEL_W +: SEL_W];
            a_code = code[i*SEL_W +: SEL_W];
            if (e_byp[lb[i]])               e_code = '0;
            else if (i < 2 && m_cfg[25])    e_code = s;
            else                            e_code = m_hold[i];
            if (a_code !== e_code) begin
                n_bad++;
                if (e_byp[lb[i]])
                    $display("FAIL R10 cyc %0d line %0d act=%h exp=%h", cyc, i, a_code, e_code);
                else if (i < 2 && m_cfg[25])
                    $display("FAIL R8 cyc %0d line %0d act=%h exp=%h", cyc, i, a_code, e_code);
                else if (m_cfg[18+i])
                    $display("FAIL R7 cyc %0d line %0d act=%h exp=%h", cyc, i, a_code, e_code);
                else
                    $display("FAIL R6 cyc %0d line %0d act=%h exp=%h", cyc, i, a_code, e_code);
            end
        end
        @(posedge clk);
        // model update at the edge
        for (int i = 0; i < NL; i++)
            if (m_cfg[18+i] || e_ld) m_hold[i] = gen_sel(cyc, i);
        if (m_pend) begin
            m_pend  = 0;
            m_armed = g;
        end else if (m_armed && !g) begin
            m_armed = 0;
            m_pend  = m_cfg[26];
        end else if (g) begin
            m_armed = 1;
        end
        if (w) m_cfg = wd & MASK;
        cyc++;
        #2;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        if (!done) begin
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        m_cfg   = 32'h2;
        m_armed = 0;
        m_pend  = 0;
        for (int i = 0; i < NL; i++) m_hold[i] = '0;

        // R1: reset state
        repeat (3) @(posedge clk);
        #5;
        n_vec++;
        if (rdata !== 32'h2 || ld !== 1'b0 || code !== '0 || byp !== '0) begin
            n_bad++;
            $display("FAIL R1 reset rdata=%h ld=%0b code=%h byp=%h exp 2/0/0/0",
                     rdata, ld, code, byp);
        end
        @(posedge clk);
        #2;
        rst_n = 1'b1;

        // R1/R5: idle after reset gives no strobe
        repeat (3) cycle(1'b0, 1'b0, '0);

        // R2: reserved bits masked
        cycle(1'b0, 1'b1, 32'hFFFF_FFFF);
        cycle(1'b0, 1'b1, 32'hA5A5_5A5A);
        cycle(1'b0, 1'b1, 32'h0000_0002);

        // R3, R4, R5: strobe timing over idle runs of 1..4 cycles
        for (int t = 0; t < 2; t++) begin
            cycle(1'b0, 1'b1, (32'(t) << 26) | 32'h2);
            for (int len = 1; len <= 4; len++) begin
                repeat (2) cycle(1'b1, 1'b0, '0);
                repeat (len) cycle(1'b0, 1'b0, '0);
            end
            repeat (3) cycle(1'b0, 1'b0, '0);
        end

        // R6..R10: load type x dynamic load x timing x mode x bypass pattern
        for (int lt = 0; lt < 2; lt++)
            for (int d = 0; d < 3; d++)
                for (int t = 0; t < 2; t++)
                    for (int m = 0; m < 4; m++)
                        for (int p = 0; p < 3; p++) begin
                            logic [4:0]  dv;
                            logic [15:0] pv;
                            logic [31:0] word;
                            dv = (d == 0) ? 5'h00 : (d == 1) ? 5'h1F : 5'h0A;
                            pv = (p == 0) ? 16'hFFFF : (p == 1) ? 16'h4A00 : 16'h2430;
                            word = (32'(t) << 26) | (32'(lt) << 25) | (32'(dv) << 18)
                                 | (32'(pv) << 2) | 32'(m);
                            cycle((cyc % 7) < 3, 1'b1, word);
                            repeat (11) cycle((cyc % 7) < 3, 1'b0, '0);
                        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule